// File: doc/BRIEF.md
# Single-Precision to Fixed-Point Converter

This block turns an IEEE-754 single-precision operand into a fixed-point integer. The caller chooses a signed or unsigned result, a 16-bit or 32-bit width, and how many fraction bits (0 to 32) the fixed-point format carries. The operand is scaled by two to the power of that count by adding it to the exponent. A right barrel shift of the 24-bit significand then yields the integer part, together with a guard bit and a sticky bit for rounding.

Rounding follows the rounding mode supplied with the operand, unless a truncate override is set. Results outside the chosen format clamp to its nearest limit. A clamped result and a NaN operand both raise the invalid flag. The inexact flag reports discarded fraction bits. A 16-bit result is widened to 32 bits, sign-extended if signed and zero-extended if unsigned. There is one register stage between the inputs and the outputs.

Top module: `float_to_fixed`

## Requirements
- R1: The result is the operand multiplied by 2^frac_bits and then rounded to an integer; frac_bits ranges 0 to 32.
- R2: The rounding mode is encoded on rmode as 0 = nearest with ties to even, 1 = toward plus infinity, 2 = toward minus infinity, 3 = toward zero.
- R3: When force_rz is 1, rounding is toward zero whatever rmode holds.
- R4: A NaN operand (exponent 0xFF, nonzero fraction, quiet or signalling) gives result 0 with invalid set and inexact clear.
- R5: An operand whose exponent field is zero (a zero or a subnormal) gives result 0 with both flags clear, even after scaling.
- R6: Inexact is set when rounding drops nonzero bits and the result does not saturate.
- R7: A signed 16-bit result clamps to -32768 and 32767 (0xFFFF8000 and 0x00007FFF on the port). A signed 32-bit result clamps to 0x80000000 and 0x7FFFFFFF.
- R8: An unsigned result whose rounded value is below zero clamps to 0. Above 0xFFFF (16-bit) or 0xFFFFFFFF (32-bit) it clamps to that limit. A negative operand that rounds to zero gives 0 and does not clamp.
- R9: Any clamp sets invalid and clears inexact, so the two flags are never set together.
- R10: An infinity clamps to the limit on the side of its sign.
- R11: A 16-bit result fills bits 31:16 with copies of bit 15 when signed and with zeros when unsigned.
- R12: Outputs show the conversion of the inputs sampled at the previous rising clock edge. An active-low rst_n clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 32 | Single-precision operand |
| is_signed | input | 1 | 1 selects a signed result |
| half | input | 1 | 1 selects a 16-bit result |
| frac_bits | input | 6 | Number of fraction bits, 0 to 32 |
| rmode | input | 2 | Rounding mode, encoded as in R2 |
| force_rz | input | 1 | Forces rounding toward zero |
| result | output | 32 | Fixed-point result |
| invalid | output | 1 | NaN operand or clamped result |
| inexact | output | 1 | Nonzero bits were discarded |

## Verification
The bench targets the following corner cases:
- Exact halfway values under nearest-even. A design that rounds ties away from zero returns 3 for 2.5.
- -2^31, which fits exactly, next to +2^31, which must clamp. An off-by-one limit either clamps the first or wraps the second.
- 32767.5, which lies in range before rounding and only overflows after the carry. A design that checks range before rounding misses this clamp.
- A negative operand converted to unsigned. It must clamp to zero when it rounds to -1, and must not clamp when it rounds to zero.
- NaN, infinities and subnormals. A design that treats their bit patterns as ordinary numbers produces large garbage values instead of zero or the limits.

// File: rtl/float_to_fixed.sv
module float_to_fixed (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] op,
  input  logic        is_signed,
  input  logic        half,
  input  logic [5:0]  frac_bits,
  input  logic [1:0]  rmode,
  input  logic        force_rz,
  output logic [31:0] result,
  output logic        invalid,
  output logic        inexact
);
  localparam int EXT_W = 56;

  logic        sgn;
  logic [7:0]  ex;
  logic [22:0] man;
  assign {sgn, ex, man} = op;

  wire is_nan  = (ex == 8'hFF) && (man != 23'd0);
  wire is_inf  = (ex == 8'hFF) && (man == 23'd0);
  wire is_tiny = (ex == 8'h00);

  wire signed [9:0] k = $signed({2'b00, ex}) - 10'sd127 + $signed({4'b0000, frac_bits});
  wire huge = is_inf || (k > 10'sd31);
  wire far  = k < -10'sd1;

  wire [EXT_W-1:0] ext = {1'b1, man, 32'd0};
  wire [5:0] sh = 6'(10'sd55 - k);

  logic [31:0] ipart;
  logic        guard, sticky;
  always_comb begin
    ipart  = 32'(ext >> sh);
    guard  = ext[sh - 6'd1];
    sticky = |(ext & ((56'd1 << (sh - 6'd1)) - 56'd1));
    if (far) begin
      ipart  = 32'd0;
      guard  = 1'b0;
      sticky = 1'b1;
    end
  end

  wire [1:0] mode = force_rz ? 2'd3 : rmode;
  wire lost = guard | sticky;
  logic up;
  always_comb begin
    case (mode)
      2'd0:    up = guard & (sticky | ipart[0]);
      2'd1:    up = lost & ~sgn;
      2'd2:    up = lost & sgn;
      default: up = 1'b0;
    endcase
  end
  wire [32:0] mag = {1'b0, ipart} + {32'd0, up};

  logic [32:0] pos_lim, neg_lim;
  always_comb begin
    case ({is_signed, half})
      2'b11:   begin pos_lim = 33'h0_0000_7FFF; neg_lim = 33'h0_0000_8000; end
      2'b10:   begin pos_lim = 33'h0_7FFF_FFFF; neg_lim = 33'h0_8000_0000; end
      2'b01:   begin pos_lim = 33'h0_0000_FFFF; neg_lim = 33'h0; end
      default: begin pos_lim = 33'h0_FFFF_FFFF; neg_lim = 33'h0; end
    endcase
  end

  wire over = huge || (sgn ? (mag > neg_lim) : (mag > pos_lim));
  wire [32:0] chosen = over ? (sgn ? -neg_lim : pos_lim) : (sgn ? -mag : mag);
  wire zero_out = is_nan || is_tiny;

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= 32'd0;
      invalid <= 1'b0;
      inexact <= 1'b0;
      seen    <= 1'b0;
    end else begin
      result  <= zero_out ? 32'd0 : chosen[31:0];
      invalid <= is_nan || (!is_tiny && over);
      inexact <= !zero_out && !over && lost;
      seen    <= 1'b1;
    end
  end

  p_nan_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(is_nan) |-> result == 32'd0 && invalid && !inexact);
  p_tiny_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(is_tiny) |-> result == 32'd0 && !invalid && !inexact);
  p_flags_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(invalid && inexact));
  p_half_sext_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(half) && $past(is_signed) |-> result[31:16] == {16{result[15]}});
  p_half_zext_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(half) && !$past(is_signed) |-> result[31:16] == 16'd0);
  p_inf_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(is_inf) |-> invalid);
endmodule

// File: tb/float_to_fixed_test.sv
module float_to_fixed_test;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic [31:0] op;
    logic        sg;
    logic        hf;
    logic [5:0]  fb;
    logic [1:0]  rm;
    logic        rz;
    logic [31:0] res;
    logic        inv;
    logic        inx;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VEC [NV] = '{
    '{32'h3F800000, 1'b1, 1'b0, 6'd0,  2'd0, 1'b0, 32'h00000001, 1'b0, 1'b0, 4'd1},  // R1
    '{32'h3FC00000, 1'b1, 1'b0, 6'd0,  2'd0, 1'b0, 32'h00000002, 1'b0, 1'b1, 4'd2},  // R2
    '{32'h40200000, 1'b1, 1'b0, 6'd0,  2'd0, 1'b0, 32'h00000002, 1'b0, 1'b1, 4'd2},  // R2
    '{32'hBFC00000, 1'b1, 1'b0, 6'd0,  2'd0, 1'b0, 32'hFFFFFFFE, 1'b0, 1'b1, 4'd2},  // R2
    '{32'h3FC00000, 1'b1, 1'b0, 6'd0,  2'd1, 1'b0, 32'h00000002, 1'b0, 1'b1, 4'd2},  // R2
    '{32'h3FC00000, 1'b1, 1'b0, 6'd0,  2'd2, 1'b0, 32'h00000001, 1'b0, 1'b1, 4'd2},  // R2
    '{32'hBFC00000, 1'b1, 1'b0, 6'd0,  2'd2, 1'b0, 32'hFFFFFFFE, 1'b0, 1'b1, 4'd2},  // R2
    '{32'hBFC00000, 1'b1, 1'b0, 6'd0,  2'd1, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b1, 4'd2},  // R2
    '{32'h3FC00000, 1'b1, 1'b0, 6'd0,  2'd1, 1'b1, 32'h00000001, 1'b0, 1'b1, 4'd3},  // R3
    '{32'hBFC00000, 1'b1, 1'b0, 6'd0,  2'd2, 1'b1, 32'hFFFFFFFF, 1'b0, 1'b1, 4'd3},  // R3
    '{32'h3F400000, 1'b1, 1'b0, 6'd2,  2'd0, 1'b0, 32'h00000003, 1'b0, 1'b0, 4'd1},  // R1
    '{32'h3F800000, 1'b1, 1'b0, 6'd16, 2'd0, 1'b0, 32'h00010000, 1'b0, 1'b0, 4'd1},  // R1
    '{32'h3F800000, 1'b1, 1'b0, 6'd31, 2'd0, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b0, 4'd7},  // R7
    '{32'hBF800000, 1'b1, 1'b0, 6'd31, 2'd0, 1'b0, 32'h80000000, 1'b0, 1'b0, 4'd7},  // R7
    '{32'h3F800000, 1'b0, 1'b0, 6'd32, 2'd0, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd8},  // R8
    '{32'h3F800000, 1'b0, 1'b0, 6'd31, 2'd0, 1'b0, 32'h80000000, 1'b0, 1'b0, 4'd1},  // R1
    '{32'h471C4000, 1'b1, 1'b1, 6'd0,  2'd0, 1'b0, 32'h00007FFF, 1'b1, 1'b0, 4'd7},  // R7
    '{32'hC71C4000, 1'b1, 1'b1, 6'd0,  2'd0, 1'b0, 32'hFFFF8000, 1'b1, 1'b0, 4'd7},  // R7
    '{32'h471C4000, 1'b0, 1'b1, 6'd0,  2'd0, 1'b0, 32'h00009C40, 1'b0, 1'b0, 4'd11}, // R11
    '{32'h4788B800, 1'b0, 1'b1, 6'd0,  2'd0, 1'b0, 32'h0000FFFF, 1'b1, 1'b0, 4'd8},  // R8
    '{32'hBF800000, 1'b0, 1'b0, 6'd0,  2'd0, 1'b0, 32'h00000000, 1'b1, 1'b0, 4'd8},  // R8
    '{32'hBE800000, 1'b0, 1'b0, 6'd0,  2'd0, 1'b0, 32'h00000000, 1'b0, 1'b1, 4'd8},  // R8
    '{32'hBE800000, 1'b0, 1'b0, 6'd0,  2'd2, 1'b0, 32'h00000000, 1'b1, 1'b0, 4'd8},  // R8
    '{32'h7FC00000, 1'b1, 1'b0, 6'd0,  2'd0, 1'b0, 32'h00000000, 1'b1, 1'b0, 4'd4},  // R4
    '{32'h7F800001, 1'b0, 1'b0, 6'd0,  2'd0, 1'b0, 32'h00000000, 1'b1, 1'b0, 4'd4},  // R4
    '{32'h7F800000, 1'b1, 1'b0, 6'd0,  2'd0, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b0, 4'd10}, // R10
    '{32'hFF800000, 1'b0, 1'b0, 6'd0,  2'd0, 1'b0, 32'h00000000, 1'b1, 1'b0, 4'd10}, // R10
    '{32'hFF800000, 1'b1, 1'b1, 6'd0,  2'd0, 1'b0, 32'hFFFF8000, 1'b1, 1'b0, 4'd10}, // R10
    '{32'h00000001, 1'b1, 1'b0, 6'd32, 2'd1, 1'b0, 32'h00000000, 1'b0, 1'b0, 4'd5},  // R5
    '{32'h80000000, 1'b1, 1'b0, 6'd0,  2'd0, 1'b0, 32'h00000000, 1'b0, 1'b0, 4'd5},  // R5
    '{32'h3F000000, 1'b1, 1'b0, 6'd0,  2'd0, 1'b0, 32'h00000000, 1'b0, 1'b1, 4'd6},  // R6
    '{32'h3F000000, 1'b1, 1'b0, 6'd0,  2'd1, 1'b0, 32'h00000001, 1'b0, 1'b1, 4'd6},  // R6
    '{32'h46FFFF00, 1'b1, 1'b1, 6'd0,  2'd0, 1'b0, 32'h00007FFF, 1'b1, 1'b0, 4'd9},  // R9
    '{32'h46FFFF00, 1'b1, 1'b1, 6'd0,  2'd0, 1'b1, 32'h00007FFF, 1'b0, 1'b1, 4'd9},  // R9
    '{32'hC7000000, 1'b1, 1'b1, 6'd0,  2'd0, 1'b0, 32'hFFFF8000, 1'b0, 1'b0, 4'd11}, // R11
    '{32'hBF800000, 1'b1, 1'b1, 6'd0,  2'd0, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b0, 4'd11}, // R11
    '{32'h3F800001, 1'b1, 1'b0, 6'd0,  2'd1, 1'b0, 32'h00000002, 1'b0, 1'b1, 4'd6}   // R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op = 32'd0;
  logic        is_signed = 1'b0, half = 1'b0, force_rz = 1'b0;
  logic [5:0]  frac_bits = 6'd0;
  logic [1:0]  rmode = 2'd0;
  logic [31:0] result;
  logic        invalid, inexact;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  float_to_fixed uut (
    .clk(clk), .rst_n(rst_n), .op(op), .is_signed(is_signed), .half(half),
    .frac_bits(frac_bits), .rmode(rmode), .force_rz(force_rz),
    .result(result), .invalid(invalid), .inexact(inexact)
  );

  task automatic check(input string tag, input logic [31:0] er, input logic ei, input logic ex);
    checks++;
    if (result !== er || invalid !== ei || inexact !== ex) begin
      errors++;
      $display("FAIL %s op=%h got %h inv=%b inx=%b expected %h inv=%b inx=%b",
               tag, op, result, invalid, inexact, er, ei, ex);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    op = 32'h3F800000;
    repeat (2) @(negedge clk);
    check("R12 reset state", 32'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op = VEC[i].op; is_signed = VEC[i].sg; half = VEC[i].hf;
      frac_bits = VEC[i].fb; rmode = VEC[i].rm; force_rz = VEC[i].rz;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].res, VEC[i].inv, VEC[i].inx);
    end
    // R12: one-cycle latency, output holds previous result until the edge
    op = 32'h41200000; is_signed = 1'b1; half = 1'b0; frac_bits = 6'd0; rmode = 2'd0; force_rz = 1'b0;
    #1;
    check("R12 before edge", 32'h00000002, 1'b0, 1'b1);
    @(negedge clk);
    check("R12 after edge", 32'd10, 1'b0, 1'b0);
    // R12: reset mid-run clears outputs
    op = 32'h7F800000;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R12 reset mid-run", 32'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", 32'h7FFFFFFF, 1'b1, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule